// File: doc/BRIEF.md
# Complement-Checked Serial Number Scanner

This engine looks through a one-time-programmable fuse array for a device serial number. A start pulse begins the search. The engine then asks the fuse sequencer for two consecutive words at a time. The first request names fuse index 0xFE, and each later request names an index two lower. A pair counts as valid when its first word is the exact bitwise inverse of its second word. The first word of the first valid pair becomes the serial number.

The search ends at the first valid pair, at a read error, or after the pair at index 2 has been checked without a match. If it ends without a match, the serial output is 0 and the found flag stays low. Every search ends with a single done pulse. The result and the found flag keep their values until the next search completes.

The sequencer port works as follows. The engine presents a request with valid, index and count, and the sequencer accepts it with ready. The sequencer then returns two response beats in order, lower index first. Each beat carries a data word and an error flag.

Top module: `serial_scan`

## Requirements
- R1: After reset, done, found and serial are all 0 and no read request is presented.
- R2: A start pulse while idle produces a first request for index 0xFE with the count field equal to 2.
- R3: A request stays presented, with a stable index, until ready is seen. When a pair does not match, the next request asks for an index 2 lower than the previous one.
- R4: When the first response word equals the bitwise complement of the second, the scan ends with found = 1 and serial = first word. This includes a first word of 0.
- R5: Index 2 is the lowest pair requested and index 0 is never requested. If no pair matches, the scan ends after index 2 with serial = 0 and found = 0, even when index 0 holds a valid pair.
- R6: An error flag on either response beat ends the scan on that beat with serial = 0 and found = 0, and no further request is issued.
- R7: done is high for exactly one cycle per scan. serial and found keep their values after done.
- R8: Start is ignored while a scan is running, including in the cycle that completes the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan (idle only) |
| rd_valid | output | 1 | Read request presented |
| rd_index | output | IW | First fuse index of the pair |
| rd_count | output | CW | Words requested (always 2) |
| rd_ready | input | 1 | Sequencer accepts the request |
| rsp_valid | input | 1 | Response beat present |
| rsp_data | input | DW | Response word |
| rsp_err | input | 1 | Response beat reports a read error |
| done | output | 1 | One-cycle end-of-scan pulse |
| found | output | 1 | A matching pair was seen |
| serial | output | DW | Serial number, 0 if none |

## Verification
Two events can share a cycle: a new start pulse and the completion of a scan on its final response beat. If the engine treated that start as fresh, it would silently launch a second search. The bench provokes this by raising start together with the second beat of every pair in a subset of sweeps, so the pulse lands on the completing beat when the planted pair is reached. It then requires that done is a single pulse and that no request appears in the cycles after completion.

// File: rtl/serial_scan.sv
module serial_scan #(
  parameter int DW = 32,
  parameter int IW = 12,
  parameter int CW = 3,
  parameter logic [IW-1:0] TOP_IDX = 'h0FE,
  parameter logic [IW-1:0] LOW_IDX = 'h002
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          rd_valid,
  output logic [IW-1:0] rd_index,
  output logic [CW-1:0] rd_count,
  input  logic          rd_ready,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  input  logic          rsp_err,
  output logic          done,
  output logic          found,
  output logic [DW-1:0] serial
);
  localparam logic [IW-1:0] STEP = IW'(2);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_LO, S_HI} st_t;
  st_t           st;
  logic [IW-1:0] idx;
  logic [DW-1:0] lo;

  wire hit = (rsp_data == ~lo);

  assign rd_valid = (st == S_REQ);
  assign rd_index = idx;
  assign rd_count = CW'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= TOP_IDX;
      lo     <= '0;
      done   <= 1'b0;
      found  <= 1'b0;
      serial <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          idx <= TOP_IDX;
          st  <= S_REQ;
        end
        S_REQ: if (rd_ready) st <= S_LO;
        S_LO: if (rsp_valid) begin
          if (rsp_err) begin
            st <= S_IDLE; done <= 1'b1; found <= 1'b0; serial <= '0;
          end else begin
            lo <= rsp_data;
            st <= S_HI;
          end
        end
        S_HI: if (rsp_valid) begin
          if (rsp_err) begin
            st <= S_IDLE; done <= 1'b1; found <= 1'b0; serial <= '0;
          end else if (hit) begin
            st <= S_IDLE; done <= 1'b1; found <= 1'b1; serial <= lo;
          end else if (idx == LOW_IDX) begin
            st <= S_IDLE; done <= 1'b1; found <= 1'b0; serial <= '0;
          end else begin
            idx <= idx - STEP;
            st  <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module serial_scan_chk #(
  parameter int DW = 32,
  parameter int IW = 12,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    st,
  input logic          rd_valid,
  input logic [IW-1:0] rd_index,
  input logic [CW-1:0] rd_count,
  input logic          rd_ready,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic          done,
  input logic          found,
  input logic [DW-1:0] serial
);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_count_two: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_count == CW'(2));
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_index)));
  a_r5_index_floor: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_index >= IW'(2) && !rd_index[0]));
  a_r6_error_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err && st >= 2'd2) |=> (done && !found && serial == '0 && !rd_valid));
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(found) && $stable(serial)));
endmodule

bind serial_scan serial_scan_chk #(.DW(DW), .IW(IW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .st(st), .rd_valid(rd_valid), .rd_index(rd_index),
  .rd_count(rd_count), .rd_ready(rd_ready), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .done(done), .found(found), .serial(serial));

// File: tb/serial_scan_tb.sv
module serial_scan_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int IW = 12;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          rd_valid;
  logic [IW-1:0] rd_index;
  logic [CW-1:0] rd_count;
  logic          rd_ready = 1'b0;
  logic          rsp_valid = 1'b0;
  logic [DW-1:0] rsp_data = '0;
  logic          rsp_err = 1'b0;
  logic          done;
  logic          found;
  logic [DW-1:0] serial;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_scan #(.DW(DW), .IW(IW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_valid(rd_valid),
    .rd_index(rd_index), .rd_count(rd_count), .rd_ready(rd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .done(done), .found(found), .serial(serial));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fill();
    for (int k = 0; k < 256; k++) mem[k] = {16'hA5C3, 8'h00, 8'(k)};
  endtask

  task automatic run_scan(input int err_idx, input int err_beat, input bit stall, input bit poke);
    int exp_reqs = 0;
    bit exp_found = 0;
    logic [DW-1:0] exp_serial = '0;
    int reqs = 0;
    int exp_idx = 'hFE;
    int guard = 0;
    int cur;
    bit fin = 0;
    for (int i = 'hFE; i >= 2; i -= 2) begin
      exp_reqs++;
      if (i == err_idx) break;
      if (mem[i] == ~mem[i+1]) begin exp_found = 1; exp_serial = mem[i]; break; end
    end
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!fin && guard < 3000) begin
      guard++;
      if (done) begin
        fin = 1;
      end else if (rd_valid) begin
        chk(rd_index == IW'(exp_idx), "R3 request index", 32'(rd_index), exp_idx);
        chk(rd_count == CW'(2), "R2 request count", 32'(rd_count), 2);
        cur = rd_index;
        reqs++;
        exp_idx -= 2;
        if (stall) begin
          @(negedge clk);
          chk(rd_valid && rd_index == IW'(cur), "R3 held request", 32'(rd_index), cur);
        end
        rd_ready = 1'b1;
        @(negedge clk) rd_ready = 1'b0;
        rsp_valid = 1'b1;
        rsp_data = mem[cur];
        rsp_err = (cur == err_idx && err_beat == 0);
        if (!rsp_err) begin
          @(negedge clk);
          rsp_data = mem[cur+1];
          rsp_err = (cur == err_idx && err_beat == 1);
          start = poke;
        end
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = 1'b0; start = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    chk(fin, "R7 done seen", 32'(fin), 1);
    chk(found == exp_found, "R4 R5 R6 found", 32'(found), 32'(exp_found));
    chk(serial == exp_serial, "R4 R5 R6 serial", serial, exp_serial);
    chk(reqs == exp_reqs, "R5 R6 request count", reqs, exp_reqs);
    @(negedge clk);
    chk(!done, "R7 done one cycle", 32'(done), 0);
    for (int w = 0; w < 3; w++) begin
      chk(!rd_valid, "R8 no restart after completion", 32'(rd_valid), 0);
      @(negedge clk);
    end
    chk(serial == exp_serial && found == exp_found, "R7 result held", serial, exp_serial);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    fill();
    repeat (3) @(negedge clk);
    chk(!done && !found && serial == '0, "R1 reset result", serial, 0);
    chk(!rd_valid, "R1 no request in reset", 32'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_valid && !done, "R1 idle after reset", 32'(rd_valid), 0);
    run_scan(-1, 0, 0, 1);
    for (int p = 2; p <= 'hFE; p += 2) begin
      fill();
      mem[p] = 32'h1234_0000 + 32'(p * 7);
      mem[p+1] = ~mem[p];
      run_scan(-1, 0, (p % 6) == 0, (p % 4) == 0);
    end
    fill(); mem[0] = 32'hCAFE_0001; mem[1] = ~mem[0];
    run_scan(-1, 0, 0, 0);
    fill(); mem[100] = '0; mem[101] = '1;
    run_scan(-1, 0, 0, 1);
    fill();
    run_scan('hFE, 0, 0, 0);
    run_scan('hFE, 1, 1, 0);
    run_scan(2, 1, 0, 1);
    fill(); mem[100] = 32'h0BAD_F00D; mem[101] = ~mem[100];
    run_scan(130, 0, 0, 0);
    fill(); mem[200] = 32'h7777_1111; mem[201] = ~mem[200];
    run_scan(100, 1, 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule